// File: doc/BRIEF.md
# Multi-Cycle Load-Store Processor Core

A small 32-bit processor core that runs one fixed-width instruction at a time. It reads each instruction word from a synchronous code memory into an instruction register and decodes the top six bits into control. It then carries the instruction through a short sequence of states. Register-to-register add and subtract go through a shared adder. Data moves between a 32-entry register file and a separate data memory only through a memory address register and a memory data register.

There are four ways to form an operand or address. A load-immediate puts its constant straight into a register. A register-indirect access uses the address held in a source register. An offset access adds a 16-bit constant to a source register. An absolute access uses a 21-bit constant as the address. There are no branches: the program counter moves forward one word per instruction until a halt instruction stops the core. Undefined opcodes pass through as no-ops.

Top module: `lsp_core`

## Requirements
- R1: While rst_ni is low the core holds the program counter, and so imem_addr_o, at 0, drives halt_o, dmem_re_o and dmem_we_o low, and clears all 32 registers to 0.
- R2: Bits [31:26] are the opcode, [25:21] rd, [20:16] rs, [15:11] rt. Opcode 6'b001010 writes rs + rt (modulo 2^32) into rd, and bits [10:0] have no effect.
- R3: Opcode 6'b000101 writes rs - rt (modulo 2^32) into rd.
- R4: Opcode 6'b000001 writes bits [20:0], zero-extended, into rd and makes no data-memory access.
- R5: Opcode 6'b000010 reads data memory at the address in rs and writes the word into rd.
- R6: Opcode 6'b000011 reads data memory at rs + zero-extended bits [15:0] (modulo 2^32) and writes the word into rd.
- R7: Opcode 6'b000100 reads data memory at zero-extended bits [20:0] and writes the word into rd.
- R8: Opcode 6'b000110 writes rd to data memory at the address in rs. Opcode 6'b000111 writes rd to rs + zero-extended bits [15:0].
- R9: Any opcode not listed in R2 to R8 or R10 changes no register and no memory, and the next instruction follows.
- R10: Opcode 6'b111111 raises halt_o. From then on halt_o stays high, imem_addr_o stays fixed and no data-memory access is made.
- R11: imem_addr_o is a word index that advances by one after each completed instruction. From the cycle its fetch starts, an instruction takes 4 clock edges if it is a register op, load-immediate or no-op, 5 if it is a store and 6 if it is a load. A halt raises halt_o on its 3rd edge.
- R12: A data read drives dmem_re_o with the address for one cycle and expects dmem_rdata_i in the next cycle. A write drives dmem_we_o with the address and dmem_wdata_o for one cycle. Accesses occur in program order and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Code memory word address (program counter) |
| imem_re_o | output | 1 | Code memory read strobe, data due next cycle |
| imem_rdata_i | input | 32 | Instruction word from code memory |
| dmem_addr_o | output | 32 | Data memory address (memory address register) |
| dmem_re_o | output | 1 | Data memory read strobe, data due next cycle |
| dmem_we_o | output | 1 | Data memory write strobe |
| dmem_wdata_o | output | 32 | Data memory write data (memory data register) |
| dmem_rdata_i | input | 32 | Data memory read data |
| halt_o | output | 1 | High once a halt instruction has executed |

## Verification
The bench runs an instruction-level model of each program and adds up the expected cycle count: 4, 5 or 6 edges per instruction and 3 for the closing halt. It counts rising edges from reset release until halt_o is seen high at a falling edge, and compares the two counts. Memory strobes are sampled at falling edges, where the address and write data of each access are stable, and this trace is compared entry by entry with the model's access list. Register contents surface through stores, so every program ends by storing all 32 registers. The final memory image is compared after the halt, and a further eight cycles then confirm that halt_o, imem_addr_o and the trace stay unchanged.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int ILEN   = 32;
  localparam int OPC_W  = 6;
  localparam int RIDX_W = 5;
  localparam int OFF_W  = 16;
  localparam int ABS_W  = 21;

  localparam logic [OPC_W-1:0] OPC_ADD  = 6'b001010;
  localparam logic [OPC_W-1:0] OPC_SUB  = 6'b000101;
  localparam logic [OPC_W-1:0] OPC_LDI  = 6'b000001;
  localparam logic [OPC_W-1:0] OPC_LD   = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_LDR  = 6'b000011;
  localparam logic [OPC_W-1:0] OPC_LDA  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_ST   = 6'b000110;
  localparam logic [OPC_W-1:0] OPC_STR  = 6'b000111;
  localparam logic [OPC_W-1:0] OPC_HALT = 6'b111111;

  typedef enum logic [2:0] {
    S_FETCH, S_LOAD_IR, S_EXEC, S_MEM, S_CAPT, S_WB, S_HALT
  } state_e;

  typedef enum logic [2:0] {
    K_NOP, K_ALU, K_LDI, K_LOAD, K_STORE, K_HALT
  } kind_e;

  typedef enum logic [1:0] {
    AM_NONE, AM_REG, AM_OFF, AM_ABS
  } amode_e;

  typedef struct packed {
    kind_e              kind;
    logic               alu_sub;
    amode_e             amode;
    logic [RIDX_W-1:0]  rd;
    logic [RIDX_W-1:0]  rs;
    logic [RIDX_W-1:0]  rt;
    logic [OFF_W-1:0]   off;
    logic [ABS_W-1:0]   cabs;
  } dec_t;
endpackage

// File: rtl/lsp_decoder.sv
module lsp_decoder
  import lsp_pkg::*;
(
  input  logic [ILEN-1:0] ir_i,
  output dec_t            dec_o
);
  logic [OPC_W-1:0] opc;

  assign opc = ir_i[ILEN-1 -: OPC_W];

  always_comb begin
    dec_o         = '0;
    dec_o.kind    = K_NOP;
    dec_o.amode   = AM_NONE;
    dec_o.rd      = ir_i[25:21];
    dec_o.rs      = ir_i[20:16];
    dec_o.rt      = ir_i[15:11];
    dec_o.off     = ir_i[OFF_W-1:0];
    dec_o.cabs    = ir_i[ABS_W-1:0];
    unique case (opc)
      OPC_ADD:  dec_o.kind = K_ALU;
      OPC_SUB: begin
        dec_o.kind    = K_ALU;
        dec_o.alu_sub = 1'b1;
      end
      OPC_LDI:  dec_o.kind = K_LDI;
      OPC_LD: begin
        dec_o.kind  = K_LOAD;
        dec_o.amode = AM_REG;
      end
      OPC_LDR: begin
        dec_o.kind  = K_LOAD;
        dec_o.amode = AM_OFF;
      end
      OPC_LDA: begin
        dec_o.kind  = K_LOAD;
        dec_o.amode = AM_ABS;
      end
      OPC_ST: begin
        dec_o.kind  = K_STORE;
        dec_o.amode = AM_REG;
      end
      OPC_STR: begin
        dec_o.kind  = K_STORE;
        dec_o.amode = AM_OFF;
      end
      OPC_HALT: dec_o.kind = K_HALT;
      default:  dec_o.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/lsp_alu.sv
module lsp_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o
);
  // single adder; subtract as a + ~b + 1
  logic [W-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign y_o   = a_i + b_eff + W'(sub_i);
endmodule

// File: rtl/lsp_regfile.sv
module lsp_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i
);
  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  // R2
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (regs_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/lsp_core.sv
module lsp_core
  import lsp_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  output logic            imem_re_o,
  input  logic [ILEN-1:0] imem_rdata_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic            dmem_re_o,
  output logic            dmem_we_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic [XLEN-1:0] dmem_rdata_i,
  output logic            halt_o
);
  state_e          state_q, state_d;
  logic [ILEN-1:0] ir_q;
  logic [XLEN-1:0] pc_q, mar_q, mdr_q, res_q;
  dec_t            dec;

  logic [RIDX-1:0] rf_raddr_b;
  logic [XLEN-1:0] rf_rdata_a, rf_rdata_b;
  logic            rf_we;
  logic [XLEN-1:0] rf_wdata;

  logic [XLEN-1:0] alu_b, alu_y, eff_addr;

  lsp_decoder u_dec (
    .ir_i  (ir_q),
    .dec_o (dec)
  );

  // port B serves rt for ALU ops, rd for stores
  assign rf_raddr_b = (dec.kind == K_STORE) ? dec.rd[RIDX-1:0] : dec.rt[RIDX-1:0];

  lsp_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (dec.rs[RIDX-1:0]),
    .rdata_a_o (rf_rdata_a),
    .raddr_b_i (rf_raddr_b),
    .rdata_b_o (rf_rdata_b),
    .we_i      (rf_we),
    .waddr_i   (dec.rd[RIDX-1:0]),
    .wdata_i   (rf_wdata)
  );

  always_comb begin
    if (dec.kind == K_ALU)       alu_b = rf_rdata_b;
    else if (dec.amode == AM_OFF) alu_b = XLEN'(dec.off);
    else                          alu_b = '0;
  end

  lsp_alu #(.W(XLEN)) u_alu (
    .a_i   (rf_rdata_a),
    .b_i   (alu_b),
    .sub_i (dec.alu_sub),
    .y_o   (alu_y)
  );

  assign eff_addr = (dec.amode == AM_ABS) ? XLEN'(dec.cabs) : alu_y;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_FETCH:   state_d = S_LOAD_IR;
      S_LOAD_IR: state_d = S_EXEC;
      S_EXEC: begin
        unique case (dec.kind)
          K_LOAD, K_STORE: state_d = S_MEM;
          K_HALT:          state_d = S_HALT;
          default:         state_d = S_WB;
        endcase
      end
      S_MEM:   state_d = (dec.kind == K_LOAD) ? S_CAPT : S_WB;
      S_CAPT:  state_d = S_WB;
      S_WB:    state_d = S_FETCH;
      S_HALT:  state_d = S_HALT;
      default: state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      ir_q    <= '0;
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        S_LOAD_IR: ir_q <= imem_rdata_i;
        S_EXEC: begin
          if (dec.kind == K_ALU) res_q <= alu_y;
          if (dec.kind == K_LDI) res_q <= XLEN'(dec.cabs);
          if (dec.kind == K_LOAD || dec.kind == K_STORE) mar_q <= eff_addr;
          if (dec.kind == K_STORE) mdr_q <= rf_rdata_b;
        end
        S_CAPT: mdr_q <= dmem_rdata_i;
        S_WB:   pc_q  <= pc_q + XLEN'(1);
        default: ;
      endcase
    end
  end

  assign rf_we    = (state_q == S_WB) &&
                    (dec.kind == K_ALU || dec.kind == K_LDI || dec.kind == K_LOAD);
  assign rf_wdata = (dec.kind == K_LOAD) ? mdr_q : res_q;

  assign imem_addr_o  = pc_q;
  assign imem_re_o    = (state_q == S_FETCH);
  assign dmem_addr_o  = mar_q;
  assign dmem_wdata_o = mdr_q;
  assign dmem_re_o    = (state_q == S_MEM) && (dec.kind == K_LOAD);
  assign dmem_we_o    = (state_q == S_MEM) && (dec.kind == K_STORE);
  assign halt_o       = (state_q == S_HALT);

  // R10
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  // R10
  halt_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(imem_addr_o));

  // R11
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_q) |-> (pc_q == $past(pc_q) + XLEN'(1)));

  // R12
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_re_o |=> (state_q == S_CAPT));

  // R12
  mar_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MEM) |-> ($past(state_q) == S_EXEC));

  // R12
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dmem_re_o && dmem_we_o));
endmodule

// File: tb/lsp_core_tb.sv
module lsp_core_tb_top;
  localparam logic [5:0] O_ADD = 6'b001010, O_SUB = 6'b000101, O_LDI = 6'b000001,
                         O_LD  = 6'b000010, O_LDR = 6'b000011, O_LDA = 6'b000100,
                         O_ST  = 6'b000110, O_STR = 6'b000111, O_HLT = 6'b111111;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr_o, dmem_addr_o, dmem_wdata_o;
  logic        imem_re_o, dmem_re_o, dmem_we_o, halt_o;
  logic [31:0] imem_rdata_i = '0;
  logic [31:0] dmem_rdata_i = '0;

  always #5 clk_i = ~clk_i;

  lsp_core dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .imem_addr_o (imem_addr_o), .imem_re_o (imem_re_o), .imem_rdata_i (imem_rdata_i),
    .dmem_addr_o (dmem_addr_o), .dmem_re_o (dmem_re_o), .dmem_we_o (dmem_we_o),
    .dmem_wdata_o (dmem_wdata_o), .dmem_rdata_i (dmem_rdata_i), .halt_o (halt_o)
  );

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  logic [31:0] em   [256];
  int          pw;

  always @(posedge clk_i) begin
    if (imem_re_o) imem_rdata_i <= imem[imem_addr_o[7:0]];
    if (dmem_re_o) dmem_rdata_i <= dmem[dmem_addr_o[7:0]];
    if (dmem_we_o) dmem[dmem_addr_o[7:0]] <= dmem_wdata_o;
  end

  // access trace sampled at falling edges
  logic [31:0] tr_a [512];
  logic [31:0] tr_d [512];
  logic        tr_w [512];
  int          tr_n = 0;
  logic [31:0] ex_a [512];
  logic [31:0] ex_d [512];
  logic        ex_w [512];
  int          ex_n;

  always @(negedge clk_i) begin
    if (!rst_ni) tr_n = 0;
    else if ((dmem_re_o || dmem_we_o) && tr_n < 512) begin
      tr_a[tr_n] = dmem_addr_o;
      tr_d[tr_n] = dmem_wdata_o;
      tr_w[tr_n] = dmem_we_o;
      tr_n++;
    end
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [5:0] op, logic [4:0] rd, logic [4:0] rs,
                                        logic [4:0] rt, logic [10:0] junk);
    return {op, rd, rs, rt, junk};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rd, logic [20:0] c);
    return {op, rd, c};
  endfunction
  function automatic logic [31:0] enc_m(logic [5:0] op, logic [4:0] rd, logic [4:0] rs,
                                        logic [15:0] c);
    return {op, rd, rs, c};
  endfunction

  task automatic emit(input logic [31:0] ins);
    imem[pw[7:0]] = ins;
    pw++;
  endtask

  task automatic new_prog();
    for (int i = 0; i < 256; i++) imem[i] = {O_HLT, 26'd0};
    for (int i = 0; i < 256; i++) begin
      logic [31:0] v;
      v = $urandom;
      dmem[i] <= v;
      em[i]    = v;
    end
    pw = 0;
  endtask

  task automatic set_mem(input int a, input logic [31:0] v);
    dmem[a] <= v;
    em[a]    = v;
  endtask

  task automatic emit_dump(input logic [15:0] base);
    for (int k = 0; k < 32; k++) emit(enc_m(O_STR, 5'(k), 5'd0, base + 16'(k)));
    emit({O_HLT, 26'd0});
  endtask

  // instruction-level model: registers, memory, access list, cycles
  task automatic iss(output int cyc, output int hpc);
    logic [31:0] r [32];
    logic [31:0] ins, a;
    logic [5:0]  op;
    logic [4:0]  rd, rs, rt;
    int          pc;
    for (int i = 0; i < 32; i++) r[i] = '0;
    pc = 0; cyc = 0; ex_n = 0; hpc = -1;
    for (int step = 0; step < 300; step++) begin
      ins = imem[pc & 255];
      op = ins[31:26]; rd = ins[25:21]; rs = ins[20:16]; rt = ins[15:11];
      if (op == O_HLT) begin
        cyc += 3; hpc = pc; break;
      end
      case (op)
        O_ADD: begin r[rd] = r[rs] + r[rt]; cyc += 4; end
        O_SUB: begin r[rd] = r[rs] - r[rt]; cyc += 4; end
        O_LDI: begin r[rd] = {11'd0, ins[20:0]}; cyc += 4; end
        O_LD, O_LDR, O_LDA: begin
          if (op == O_LD)       a = r[rs];
          else if (op == O_LDR) a = r[rs] + {16'd0, ins[15:0]};
          else                  a = {11'd0, ins[20:0]};
          ex_a[ex_n] = a; ex_w[ex_n] = 1'b0; ex_d[ex_n] = '0; ex_n++;
          r[rd] = em[a[7:0]]; cyc += 6;
        end
        O_ST, O_STR: begin
          a = (op == O_ST) ? r[rs] : r[rs] + {16'd0, ins[15:0]};
          ex_a[ex_n] = a; ex_w[ex_n] = 1'b1; ex_d[ex_n] = r[rd]; ex_n++;
          em[a[7:0]] = r[rd]; cyc += 5;
        end
        default: cyc += 4;
      endcase
      pc++;
    end
  endtask

  task automatic run_prog(input string tag);
    int exp_cyc, exp_hpc, cyc, n0;
    logic [31:0] a0;
    iss(exp_cyc, exp_hpc);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    // R1
    chk(imem_addr_o == 0 && !halt_o && !dmem_re_o && !dmem_we_o, "R1", "reset outputs",
        {imem_addr_o[28:0], halt_o, dmem_re_o, dmem_we_o}, 32'd0);
    rst_ni = 1'b1;
    cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk_i);
      cyc++;
      @(negedge clk_i);
      if (halt_o) break;
    end
    // R11
    chk(cyc == exp_cyc, "R11", {tag, " cycles to halt"}, 32'(cyc), 32'(exp_cyc));
    chk(imem_addr_o == 32'(exp_hpc), "R11", {tag, " halt pc"}, imem_addr_o, 32'(exp_hpc));
    // R12
    chk(tr_n == ex_n, "R12", {tag, " access count"}, 32'(tr_n), 32'(ex_n));
    for (int i = 0; i < ex_n && i < tr_n; i++) begin
      chk(tr_a[i] == ex_a[i] && tr_w[i] == ex_w[i] && (!ex_w[i] || tr_d[i] == ex_d[i]),
          "R12", $sformatf("%s access %0d addr/we/data", tag, i),
          tr_w[i] ? tr_d[i] ^ tr_a[i] : tr_a[i], ex_w[i] ? ex_d[i] ^ ex_a[i] : ex_a[i]);
    end
    n0 = tr_n; a0 = imem_addr_o;
    repeat (8) @(negedge clk_i);
    // R10
    chk(halt_o && tr_n == n0 && imem_addr_o == a0, "R10", {tag, " quiet after halt"},
        {imem_addr_o[30:0], halt_o}, {a0[30:0], 1'b1});
    for (int i = 0; i < 256; i++)
      chk(dmem[i] === em[i], tag, $sformatf("mem[%0d]", i), dmem[i], em[i]);
  endtask

  function automatic logic [31:0] rnd_ins();
    logic [5:0] op;
    logic [4:0] rd, rs, rt;
    rd = 5'($urandom); rs = 5'($urandom); rt = 5'($urandom);
    case ($urandom % 10)
      0, 9: return enc_r(O_ADD, rd, rs, rt, 11'($urandom));
      1: return enc_r(O_SUB, rd, rs, rt, 11'($urandom));
      2: return enc_i(O_LDI, rd, 21'($urandom));
      3: return enc_m(O_LD, rd, rs, 16'($urandom));
      4: return enc_m(O_LDR, rd, rs, 16'($urandom));
      5: return enc_i(O_LDA, rd, 21'($urandom));
      6: return enc_m(O_ST, rd, rs, 16'($urandom));
      7: return enc_m(O_STR, rd, rs, 16'($urandom));
      default: begin
        op = 6'($urandom);
        if (op inside {O_ADD, O_SUB, O_LDI, O_LD, O_LDR, O_LDA, O_ST, O_STR, O_HLT})
          op = 6'b110011;
        return {op, rd, rs, rt, 11'($urandom)};
      end
    endcase
  endfunction

  bit timed_out = 1'b0;

  initial begin
    repeat (150000) @(posedge clk_i);
    timed_out = 1'b1;
    n_chk++; n_err++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));

    // random program leaves registers dirty, then R1 dump after fresh reset
    new_prog();
    for (int i = 0; i < 30; i++) emit(rnd_ins());
    emit_dump(16'd100);
    run_prog("RND");
    new_prog();
    emit_dump(16'd64);
    run_prog("R1");

    // R2 and R3: add with junk low bits, sub with wrap
    new_prog();
    emit(enc_i(O_LDI, 5'd1, 21'd5));
    emit(enc_i(O_LDI, 5'd3, 21'd7));
    emit(enc_r(O_ADD, 5'd2, 5'd1, 5'd3, 11'h7FF));
    emit(enc_i(O_LDI, 5'd20, 21'h1FFFFF));
    emit(enc_r(O_ADD, 5'd21, 5'd20, 5'd20, 11'h555));
    emit_dump(16'd32);
    run_prog("R2");
    new_prog();
    emit(enc_i(O_LDI, 5'd1, 21'd5));
    emit(enc_i(O_LDI, 5'd3, 21'd7));
    emit(enc_r(O_SUB, 5'd4, 5'd1, 5'd3, 11'h0));
    emit(enc_r(O_SUB, 5'd5, 5'd3, 5'd1, 11'h3AB));
    emit(enc_r(O_SUB, 5'd6, 5'd6, 5'd6, 11'h0));
    emit_dump(16'd40);
    run_prog("R3");

    // R4: widest immediate zero-extended
    new_prog();
    emit(enc_i(O_LDI, 5'd7, 21'h1FFFFF));
    emit(enc_i(O_LDI, 5'd8, 21'h100000));
    emit_dump(16'd48);
    run_prog("R4");

    // R5: register indirect, values 145 at 3 and 231 at 5
    new_prog();
    set_mem(3, 32'd145);
    set_mem(5, 32'd231);
    emit(enc_i(O_LDI, 5'd1, 21'd3));
    emit(enc_m(O_LD, 5'd9, 5'd1, 16'hBEEF));
    emit_dump(16'd128);
    run_prog("R5");

    // R6: offset 2 and offset wrap past 2^32
    new_prog();
    set_mem(5, 32'd231);
    emit(enc_i(O_LDI, 5'd1, 21'd3));
    emit(enc_m(O_LDR, 5'd9, 5'd1, 16'd2));
    emit(enc_i(O_LDI, 5'd2, 21'd1));
    emit(enc_r(O_SUB, 5'd3, 5'd0, 5'd2, 11'd0));
    emit(enc_m(O_LDR, 5'd4, 5'd3, 16'hFFFF));
    emit_dump(16'd136);
    run_prog("R6");

    // R7: absolute address with top bit of the constant set
    new_prog();
    emit(enc_i(O_LDA, 5'd11, 21'h1FFF05));
    emit(enc_i(O_LDA, 5'd12, 21'd6));
    emit_dump(16'd144);
    run_prog("R7");

    // R8: stores then reload
    new_prog();
    emit(enc_i(O_LDI, 5'd1, 21'd10));
    emit(enc_i(O_LDI, 5'd6, 21'h12345));
    emit(enc_m(O_ST, 5'd6, 5'd1, 16'hFFFF));
    emit(enc_m(O_STR, 5'd6, 5'd1, 16'd1));
    emit(enc_m(O_LDR, 5'd7, 5'd1, 16'd1));
    emit(enc_m(O_LD, 5'd8, 5'd1, 16'd0));
    emit_dump(16'd160);
    run_prog("R8");

    // R9: undefined opcodes between live instructions
    new_prog();
    emit(enc_i(O_LDI, 5'd2, 21'd77));
    emit({6'b110011, 5'd2, 5'd2, 5'd2, 11'h7FF});
    emit({6'b000000, 5'd2, 21'h1FFFFF});
    emit({6'b111110, 5'd0, 5'd2, 16'hFFFF});
    emit(enc_r(O_ADD, 5'd3, 5'd2, 5'd2, 11'd0));
    emit_dump(16'd192);
    run_prog("R9");

    // R10: halt as the very first instruction
    new_prog();
    run_prog("R10");

    // constrained random programs
    for (int p = 0; p < 6; p++) begin
      new_prog();
      for (int i = 0; i < 40; i++) emit(rnd_ins());
      emit_dump(16'($urandom % 200));
      run_prog("RND");
    end

    if (!timed_out) begin
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule